// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block steers up to 64 device interrupt lines to four processors. A single global request word records which devices are asking for service. Each processor has its own enable mask, and it sees a pending word that is always the mask ANDed with the request word. Devices raise and withdraw requests with one-cycle pulse vectors. Software programs the masks through a small 64-bit register port and can read back every mask, every pending word and the request word.

Each processor has a level interrupt output. It is high while any bit of that processor's pending word is set. There are also two one-cycle event outputs per processor. One pulses when some pending bit turns on, and the other pulses when some pending bit turns off. Such a transition can come from a mask write, a device raise or a device withdraw. An event fires only on an actual change of a pending bit.

Top module: `irq_router`

## Requirements
- R1: After reset, all masks and the request word are zero, no interrupt or event output is active, and every readable register reads zero.
- R2: For every processor c, the pending word read back always equals mask c AND the request word.
- R3: A pulse on `dev_set[n]` sets request bit n on the next clock edge. From that edge on, `irq_o[c]` is high for every processor c whose mask has bit n set.
- R4: A pulse on `dev_clr[n]` while request bit n is already zero is spurious. It leaves all registers and outputs unchanged.
- R5: A pulse on `dev_clr[n]` while request bit n is one clears that bit. Every processor whose pending word had bit n set gets a withdraw event, and its level output falls if no other pending bit remains.
- R6: `post_o[c]` pulses for one cycle, right after the edge at which any pending bit of processor c went from 0 to 1. `drop_o[c]` pulses right after an edge at which any pending bit of processor c went from 1 to 0. Raising a request that is already set produces no event.
- R7: A mask write produces a raise event for mask bits that are newly set and pending. It produces a withdraw event for bits that were pending before the write and are not pending after it.
- R8: The register index is the byte address shifted right by 6. Index c (0..3) is mask c, read/write. Index 4+c is pending c, read-only. Index 8 is the request word, read-only. Address bits 5:0 are ignored.
- R9: Only 64-bit accesses (`acc_size` = 3) are legal. Any other size returns an error and has no effect.
- R10: A write to a pending word or to the request word returns an error and changes nothing.
- R11: An access to any index above 8 returns an error.
- R12: When `dev_set[n]` and `dev_clr[n]` pulse in the same cycle, the set takes effect and request bit n ends as one.
- R13: Each access gets exactly one response, with `rsp_valid` high in the cycle after `acc_valid`. Read data reflects the state before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | log2 of access bytes; 3 = 64-bit |
| acc_addr | input | AW (12) | Byte address; index = addr >> 6 |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after access |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | 64 | Read data (zero on error) |
| dev_set | input | NLINES (64) | Per-device raise pulses |
| dev_clr | input | NLINES (64) | Per-device withdraw pulses |
| irq_o | output | NCPU (4) | Per-processor level interrupt |
| post_o | output | NCPU (4) | Per-processor raise event pulse |
| drop_o | output | NCPU (4) | Per-processor withdraw event pulse |

## Verification
The assertions assume that `acc_size` and `acc_write` are meaningful only while `acc_valid` is high. They also assume that raise and withdraw vectors may overlap on any bit. They check only one-cycle relations, such as a raise event implying a live level output and a withdraw event implying the level was high a cycle earlier. The stimulus drives every input on the falling edge and holds it for exactly one cycle. It mixes directed cases with randomised traffic over all indices, all sizes, and overlapping set and withdraw vectors, so every input combination the assertions cover is legal.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NCPU   = 4,
  parameter int NLINES = 64,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [AW-1:0]     acc_addr,
  input  logic [63:0]       acc_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  input  logic [NLINES-1:0] dev_set,
  input  logic [NLINES-1:0] dev_clr,
  output logic [NCPU-1:0]   irq_o,
  output logic [NCPU-1:0]   post_o,
  output logic [NCPU-1:0]   drop_o
);
  localparam int IDXW = AW - 6;
  localparam logic [IDXW-1:0] REQ_IDX = IDXW'(2 * NCPU);

  logic [NLINES-1:0] mask_q [NCPU];
  logic [NLINES-1:0] req_q;
  logic [IDXW-1:0]   idx;
  logic              is64;
  logic              hit;
  logic              ro_hit;
  logic [63:0]       rd;

  assign idx  = acc_addr[AW-1:6];
  assign is64 = (acc_size == 2'd3);

  wire [NLINES-1:0] req_d = (req_q & ~dev_clr) | dev_set;

  always_comb begin
    rd     = '0;
    hit    = (idx == REQ_IDX);
    ro_hit = (idx == REQ_IDX);
    if (idx == REQ_IDX) rd = 64'(req_q);
    for (int c = 0; c < NCPU; c++) begin
      if (idx == IDXW'(c)) begin
        rd  = 64'(mask_q[c]);
        hit = 1'b1;
      end
      if (idx == IDXW'(NCPU + c)) begin
        rd     = 64'(mask_q[c] & req_q);
        hit    = 1'b1;
        ro_hit = 1'b1;
      end
    end
  end

  wire err_now = !is64 || !hit || (acc_write && ro_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_q     <= req_d;
      rsp_valid <= acc_valid;
      rsp_err   <= acc_valid && err_now;
      rsp_rdata <= (acc_valid && !err_now && !acc_write) ? rd : '0;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    wire               wr_c   = acc_valid && acc_write && is64 && (idx == IDXW'(c));
    wire [NLINES-1:0]  mask_d = wr_c ? acc_wdata[NLINES-1:0] : mask_q[c];
    wire [NLINES-1:0]  pend_q = mask_q[c] & req_q;
    wire [NLINES-1:0]  pend_d = mask_d & req_d;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[c] <= '0;
        post_o[c] <= 1'b0;
        drop_o[c] <= 1'b0;
      end else begin
        mask_q[c] <= mask_d;
        post_o[c] <= |(pend_d & ~pend_q);
        drop_o[c] <= |(pend_q & ~pend_d);
      end
    end

    assign irq_o[c] = |pend_q;

    AST_POST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      post_o[c] |-> irq_o[c]); // R6
    AST_DROP_PREV: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o[c] |-> $past(irq_o[c])); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write) |=> $stable(mask_q[c])); // R10
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid); // R13
  AST_RSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid); // R13
  AST_NARROW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size != 2'd3) |=> rsp_err); // R9
  AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & $past(dev_clr & ~req_q & ~dev_set)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~req_q & $past(dev_set)) == '0)); // R12
endmodule

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [1:0]  acc_size = 0;
  logic [11:0] acc_addr = 0;
  logic [63:0] acc_wdata = 0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [63:0] dev_set = 0, dev_clr = 0;
  logic [3:0]  irq_o, post_o, drop_o;

  always #10 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dev_set(dev_set), .dev_clr(dev_clr), .irq_o(irq_o), .post_o(post_o), .drop_o(drop_o));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] mm [4];
  logic [63:0] mr;
  logic        e_rv, e_err;
  logic [63:0] e_rd;
  logic [3:0]  e_post, e_drop, e_irq;

  task automatic model_reset();
    for (int c = 0; c < 4; c++) mm[c] = 0;
    mr = 0; e_rv = 0; e_err = 0; e_rd = 0; e_post = 0; e_drop = 0; e_irq = 0;
  endtask

  task automatic model_step();
    int idx;
    logic [63:0] po [4];
    logic [63:0] pn;
    bit is64;
    idx = int'(acc_addr >> 6);
    is64 = (acc_size == 3);
    e_rv = acc_valid;
    e_err = acc_valid && (!is64 || idx > 8 || (acc_write && idx >= 4));
    e_rd = 0;
    if (acc_valid && !e_err && !acc_write) begin
      if (idx < 4) e_rd = mm[idx];
      else if (idx < 8) e_rd = mm[idx-4] & mr;
      else e_rd = mr;
    end
    for (int c = 0; c < 4; c++) po[c] = mm[c] & mr;
    mr = (mr & ~dev_clr) | dev_set;
    if (acc_valid && acc_write && is64 && idx < 4) mm[idx] = acc_wdata;
    for (int c = 0; c < 4; c++) begin
      pn = mm[c] & mr;
      e_post[c] = |(pn & ~po[c]);
      e_drop[c] = |(po[c] & ~pn);
      e_irq[c]  = |pn;
    end
  endtask

  task automatic compare(string tag);
    bit bad;
    bad = (rsp_valid !== e_rv) || (rsp_err !== e_err) || (irq_o !== e_irq) ||
          (post_o !== e_post) || (drop_o !== e_drop) ||
          (e_rv && !e_err && rsp_rdata !== e_rd);
    n_cmp++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got v=%0b e=%0b rd=%h irq=%b post=%b drop=%b exp v=%0b e=%0b rd=%h irq=%b post=%b drop=%b",
        tag, rsp_valid, rsp_err, rsp_rdata, irq_o, post_o, drop_o,
        e_rv, e_err, e_rd, e_irq, e_post, e_drop);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_size = 0; acc_addr = 0; acc_wdata = 0;
    dev_set = 0; dev_clr = 0;
  endtask

  task automatic acc(bit w, int idx, logic [63:0] d, string tag,
                     logic [1:0] sz = 2'd3, logic [5:0] lo = 0);
    acc_valid = 1; acc_write = w; acc_size = sz;
    acc_addr = {idx[5:0], lo}; acc_wdata = d;
    step(tag);
  endtask

  task automatic dev(logic [63:0] s, logic [63:0] c, string tag);
    dev_set = s; dev_clr = c;
    step(tag);
  endtask

  task automatic read_pend(string tag);
    for (int i = 4; i <= 8; i++) acc(0, i, 0, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1 idle after reset");
    for (int i = 0; i <= 8; i++) acc(0, i, 0, "R1 reset readback");

    acc(1, 0, 64'h5, "R8 mask0 write");
    acc(1, 1, 64'h4, "R8 mask1 write");
    acc(1, 2, 64'h8000_0000_0000_0000, "R8 mask2 write");
    acc(1, 3, '1, "R8 mask3 write");
    dev(64'h4, 0, "R3 raise bit2");
    dev(64'h4, 0, "R6 raise already set, no event");
    dev(64'h8000_0000_0000_0000, 0, "R3 raise bit63");
    read_pend("R2 pending readback");
    dev(0, 64'h20, "R4 spurious clear");
    read_pend("R4 state unchanged");
    dev(0, 64'h4, "R5 clear bit2");
    read_pend("R2 after clear");
    dev(64'h1, 0, "R3 raise bit0");
    acc(1, 0, 64'h4, "R7 mask drop pending bit0");
    acc(1, 0, 64'h1, "R7 mask add pending bit0");
    acc(1, 1, 64'h1, "R7 mask change on cpu1", 2'd3, 6'h18);
    dev(64'h10, 64'h10, "R12 set and clear same bit");
    acc(0, 8, 0, "R12 request readback");
    acc(1, 0, 64'h0, "R9 narrow write ignored", 2'd2);
    acc(0, 0, 0, "R9 narrow read error", 2'd0);
    acc(0, 0, 0, "R9 mask0 unchanged");
    acc(1, 5, '1, "R10 pending write rejected");
    acc(1, 8, 0, "R10 request write rejected");
    read_pend("R10 state unchanged");
    acc(0, 9, 0, "R11 unmapped read");
    acc(1, 40, 64'h1, "R11 unmapped write");
    acc(0, 2, 0, "R8 offset within slot", 2'd3, 6'h3f);
    for (int k = 0; k < 400; k++) begin
      acc_valid = $urandom_range(0, 1); acc_write = $urandom_range(0, 1);
      acc_size = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 2)) : 2'd3;
      acc_addr = {6'($urandom_range(0, 10)), 6'($urandom)};
      acc_wdata = {$urandom, $urandom} & {$urandom, $urandom};
      dev_set = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      dev_clr = {$urandom, $urandom} & {$urandom, $urandom};
      step("R2 R6 R13 random traffic");
    end
    read_pend("R2 final readback");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule